// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out slots of an on-chip Ethernet packet memory. The memory holds `NUM_SLOTS` slots of 2 KB each, which is 8 KB at the default of four. Each slot is named by a packet number. A host drives one command at a time on a small command port. The commands are:

- allocate a slot for a frame it will transmit;
- queue a filled slot for transmission;
- release the received slot at the head of the receive queue;
- free a transmitted slot;
- reset the whole allocator.

Frame arrival from the wire is modelled by the `rxArrive` strobe. That strobe takes a slot and pushes its number into a receive queue. Completion of a transmission is modelled by the `txDone` strobe, which pops the transmit queue.

An allocation finishes one cycle after the command is accepted. It reports its result, a packet number and a failure flag, and raises an allocation interrupt bit. The host clears that bit by pulsing an acknowledge, which models writing a one. Release, free and reset keep a busy flag high for a fixed number of cycles. Any command presented while busy is high, or while an allocation is still pending, is dropped. The host sizes each request as a page-count field. It takes the frame length (at least 60), clears bit 0, adds 6 header bytes and shifts right by 8.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset the block shows:
  - `busy`, `allocIrq`, `txIrq` and `allocFailed` all 0;
  - `rxEmpty` 1;
  - `freeUnits` equal to `NUM_SLOTS`.
- R2: An allocate command (op 2) is sampled at one clock edge and resolved at the next. If it succeeds, `allocPn` is the lowest-numbered free slot, `allocFailed` is 0 and that slot becomes used.
- R3: An allocate fails when no slot is free, or when its page field exceeds `PAGES_PER_SLOT-1` (7 by default). A failure sets `allocFailed`, leaves `allocIrq` unchanged and consumes no slot.
- R4: `allocIrq` is set by a successful allocation and `txIrq` by a transmit completion. Each is cleared by a one-cycle pulse on `ackAlloc` or `ackTx`. A set in the same cycle wins over the clear.
- R5: Accepted reset (op 1), release (op 4) and free (op 5) commands hold `busy` high for exactly `BUSY_CYCLES` cycles (4), starting with the edge that samples the command.
- R6: A command presented while `busy` is high, or in the cycle when an allocation resolves, has no effect.
- R7: On `rxArrive`, the lowest free slot is marked used and its number is pushed into the receive queue. If an allocation resolves in the same cycle, that allocation takes the lowest free slot first. With no free slot the arrival is dropped. `rxPn` shows the head of the queue, and `rxEmpty` is 1 when the queue is empty.
- R8: Release frees the slot at the head of the receive queue and pops it.
- R9: Free returns slot `cmdPn` to the free pool.
- R10: Enqueue (op 3) pushes `cmdPn` into the transmit queue. When the queue is not empty, `txDone` pops its head into `txDonePn` in order and sets `txIrq`. When the queue is empty, `txDone` has no effect.
- R11: Reset frees every slot and empties both queues.
- R12: `freeUnits` equals the number of free 2 KB slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | 0 none, 1 reset, 2 allocate, 3 enqueue, 4 release, 5 free |
| cmdPages | input | PAGE_W | Page-count field of an allocate |
| cmdPn | input | clog2(NUM_SLOTS) | Packet number for enqueue and free |
| ackAlloc | input | 1 | Clears allocIrq |
| ackTx | input | 1 | Clears txIrq |
| rxArrive | input | 1 | A frame arrives from the wire |
| txDone | input | 1 | The head transmit frame has been sent |
| busy | output | 1 | A release, free or reset is still running |
| allocPn | output | clog2(NUM_SLOTS) | Last granted packet number |
| allocFailed | output | 1 | The last allocation failed |
| allocIrq | output | 1 | Allocation-done interrupt bit |
| txIrq | output | 1 | Transmit-done interrupt bit |
| txDonePn | output | clog2(NUM_SLOTS) | Packet number of the last completed transmit |
| rxPn | output | clog2(NUM_SLOTS) | Head of the receive queue |
| rxEmpty | output | 1 | The receive queue is empty |
| freeUnits | output | clog2(NUM_SLOTS+1) | Free 2 KB slots |

## Verification
The results of an allocation are due after the second rising edge that follows the cycle in which the command is driven. The bench therefore drives the command at a falling edge and reads the results two falling edges later.

The effects of strobes, acknowledges, enqueue, release and free appear after the first edge. The bench samples them at the next falling edge.

`busy` is counted in falling edges from the first sample after the command until it drops, and that count must equal `BUSY_CYCLES`. Dropped commands are placed in the cycle right after a free and are judged through `allocIrq` and `freeUnits`.

// File: rtl/pkt_page_alloc_pkg.sv
package pkt_page_alloc_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_RESET   = 3'd1,
    OP_ALLOC   = 3'd2,
    OP_ENQ     = 3'd3,
    OP_RELEASE = 3'd4,
    OP_FREE    = 3'd5
  } cmd_op_e;

  // Strobes from the command control to the slot datapath.
  typedef struct packed {
    logic doReset;
    logic doGrant;
    logic doEnq;
    logic doRelease;
    logic doFree;
  } ctrl_strobe_t;

endpackage

// File: rtl/ppa_pn_fifo.sv
module ppa_pn_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] cnt;
  logic          doPop, doPush;

  assign empty  = (cnt == '0);
  assign doPop  = pop && !empty;
  assign doPush = push && ((cnt != CW'(DEPTH)) || doPop);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      cnt <= cnt + 1'b1;
      else if (doPop && !doPush) cnt <= cnt - 1'b1;
    end
  end

  assign headData = mem[rdPtr];

endmodule

// File: rtl/ppa_cmd_ctrl.sv
module ppa_cmd_ctrl
  import pkt_page_alloc_pkg::*;
#(
  parameter int BUSY_CYCLES    = 4,
  parameter int PAGE_W         = 5,
  parameter int PAGES_PER_SLOT = 8,
  parameter int PN_W           = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [PAGE_W-1:0] cmdPages,
  input  logic              ackAlloc,
  input  logic              ackTx,
  input  logic              grantOk,
  input  logic [PN_W-1:0]   grantPn,
  input  logic              txPopped,
  output ctrl_strobe_t      strb,
  output logic              busy,
  output logic              allocIrq,
  output logic              txIrq,
  output logic [PN_W-1:0]   allocPn,
  output logic              allocFailed
);
  localparam int BC_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [PAGE_W-1:0] MAX_FIELD = PAGE_W'(PAGES_PER_SLOT - 1);

  logic [BC_W-1:0] busyCnt;
  logic            pend, pendOversize;
  logic            accept, busyStart;
  cmd_op_e         op;

  assign op     = cmd_op_e'(cmdOp);
  assign busy   = (busyCnt != '0);
  assign accept = cmdValid && !busy && !pend;

  always_comb begin
    strb           = '0;
    strb.doReset   = accept && (op == OP_RESET);
    strb.doEnq     = accept && (op == OP_ENQ);
    strb.doRelease = accept && (op == OP_RELEASE);
    strb.doFree    = accept && (op == OP_FREE);
    strb.doGrant   = pend && !pendOversize && grantOk;
  end

  assign busyStart = strb.doReset || strb.doRelease || strb.doFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt      <= '0;
      pend         <= 1'b0;
      pendOversize <= 1'b0;
      allocPn      <= '0;
      allocFailed  <= 1'b0;
      allocIrq     <= 1'b0;
      txIrq        <= 1'b0;
    end else begin
      if (busyStart)         busyCnt <= BC_W'(BUSY_CYCLES);
      else if (busyCnt != 0) busyCnt <= busyCnt - 1'b1;
      pend         <= accept && (op == OP_ALLOC);
      pendOversize <= (cmdPages > MAX_FIELD);
      if (pend) begin
        if (strb.doGrant) begin
          allocPn     <= grantPn;
          allocFailed <= 1'b0;
        end else begin
          allocFailed <= 1'b1;
        end
      end
      allocIrq <= strb.doGrant || (allocIrq && !ackAlloc);
      txIrq    <= txPopped || (txIrq && !ackTx);
    end
  end

  // R4: a granted allocation leaves the interrupt bit set
  a_r4_alloc_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.doGrant |=> allocIrq);

  // R3: a failed allocation flags failure and does not touch the interrupt bit
  a_r3_fail_keeps_irq: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !strb.doGrant && !ackAlloc) |=> (allocFailed && allocIrq == $past(allocIrq)));

  // R5: an accepted release, free or reset raises busy
  a_r5_busy_raised: assert property (@(posedge clk) disable iff (!rstN)
    busyStart |=> busy);

endmodule

// File: rtl/ppa_slot_datapath.sv
module ppa_slot_datapath
  import pkt_page_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PN_W      = 2,
  parameter int CNT_W     = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_strobe_t    strb,
  input  logic [PN_W-1:0] cmdPn,
  input  logic            rxArrive,
  input  logic            txDone,
  output logic            grantOk,
  output logic [PN_W-1:0] grantPn,
  output logic [PN_W-1:0] rxPn,
  output logic            rxEmpty,
  output logic            txPopped,
  output logic [PN_W-1:0] txDonePn,
  output logic [CNT_W-1:0] freeUnits
);
  logic [NUM_SLOTS-1:0] used, grantMask, rxMask, relMask, freeMask, rxAvail;
  logic                 rxOk, rxTake, txEmpty;
  logic [PN_W-1:0]      rxSlot, txHead;

  // Allocation takes the lowest free slot.
  always_comb begin
    grantOk = 1'b0;
    grantPn = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!used[i]) begin
        grantOk = 1'b1;
        grantPn = PN_W'(i);
      end
    end
  end

  assign grantMask = strb.doGrant ? (NUM_SLOTS'(1) << grantPn) : '0;
  assign rxAvail   = ~used & ~grantMask;

  // A received frame takes the lowest slot left after any grant.
  always_comb begin
    rxOk   = 1'b0;
    rxSlot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (rxAvail[i]) begin
        rxOk   = 1'b1;
        rxSlot = PN_W'(i);
      end
    end
  end

  assign rxTake   = rxArrive && rxOk && !strb.doReset;
  assign rxMask   = rxTake ? (NUM_SLOTS'(1) << rxSlot) : '0;
  assign relMask  = (strb.doRelease && !rxEmpty) ? (NUM_SLOTS'(1) << rxPn) : '0;
  assign freeMask = strb.doFree ? (NUM_SLOTS'(1) << cmdPn) : '0;
  assign txPopped = txDone && !txEmpty && !strb.doReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      used     <= '0;
      txDonePn <= '0;
    end else begin
      if (strb.doReset) used <= '0;
      else              used <= (used & ~relMask & ~freeMask) | grantMask | rxMask;
      if (txPopped) txDonePn <= txHead;
    end
  end

  always_comb begin
    freeUnits = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!used[i]) freeUnits = freeUnits + 1'b1;
    end
  end

  ppa_pn_fifo #(.DEPTH(NUM_SLOTS), .W(PN_W)) rxQ_i (
    .clk(clk), .rstN(rstN), .flush(strb.doReset),
    .push(rxTake), .pushData(rxSlot), .pop(strb.doRelease),
    .headData(rxPn), .empty(rxEmpty)
  );

  ppa_pn_fifo #(.DEPTH(NUM_SLOTS), .W(PN_W)) txQ_i (
    .clk(clk), .rstN(rstN), .flush(strb.doReset),
    .push(strb.doEnq), .pushData(cmdPn), .pop(txPopped),
    .headData(txHead), .empty(txEmpty)
  );

  // R7: a grant and a received frame never claim the same slot
  always_comb begin
    if (rstN) a_r7_disjoint_claims: assert ((grantMask & rxMask) == '0);
  end

  // R11: after a reset every slot is free and the receive queue is empty
  a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.doReset |=> (rxEmpty && freeUnits == CNT_W'(NUM_SLOTS)));

  // R10: a completed transmit reports the queue head it popped
  a_r10_tx_order: assert property (@(posedge clk) disable iff (!rstN)
    txPopped |=> (txDonePn == $past(txHead)));

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_page_alloc_pkg::*;
#(
  parameter int NUM_SLOTS      = 4,
  parameter int PAGE_W         = 5,
  parameter int PAGES_PER_SLOT = 8,
  parameter int BUSY_CYCLES    = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cmdValid,
  input  logic [2:0]                     cmdOp,
  input  logic [PAGE_W-1:0]              cmdPages,
  input  logic [$clog2(NUM_SLOTS)-1:0]   cmdPn,
  input  logic                           ackAlloc,
  input  logic                           ackTx,
  input  logic                           rxArrive,
  input  logic                           txDone,
  output logic                           busy,
  output logic [$clog2(NUM_SLOTS)-1:0]   allocPn,
  output logic                           allocFailed,
  output logic                           allocIrq,
  output logic                           txIrq,
  output logic [$clog2(NUM_SLOTS)-1:0]   txDonePn,
  output logic [$clog2(NUM_SLOTS)-1:0]   rxPn,
  output logic                           rxEmpty,
  output logic [$clog2(NUM_SLOTS+1)-1:0] freeUnits
);
  localparam int PN_W  = $clog2(NUM_SLOTS);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);

  ctrl_strobe_t    strb;
  logic            grantOk, txPopped;
  logic [PN_W-1:0] grantPn;

  ppa_cmd_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W),
    .PAGES_PER_SLOT(PAGES_PER_SLOT), .PN_W(PN_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPages(cmdPages), .ackAlloc(ackAlloc), .ackTx(ackTx),
    .grantOk(grantOk), .grantPn(grantPn), .txPopped(txPopped),
    .strb(strb), .busy(busy), .allocIrq(allocIrq), .txIrq(txIrq),
    .allocPn(allocPn), .allocFailed(allocFailed)
  );

  ppa_slot_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .PN_W(PN_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdPn(cmdPn),
    .rxArrive(rxArrive), .txDone(txDone), .grantOk(grantOk),
    .grantPn(grantPn), .rxPn(rxPn), .rxEmpty(rxEmpty),
    .txPopped(txPopped), .txDonePn(txDonePn), .freeUnits(freeUnits)
  );

endmodule

// File: tb/pkt_page_alloc_tb_top.sv
module pkt_page_alloc_tb_top;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [4:0] cmdPages = 5'd0;
  logic [1:0] cmdPn = 2'd0;
  logic ackAlloc = 1'b0, ackTx = 1'b0, rxArrive = 1'b0, txDone = 1'b0;
  logic busy, allocFailed, allocIrq, txIrq, rxEmpty;
  logic [1:0] allocPn, txDonePn, rxPn;
  logic [2:0] freeUnits;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pkt_page_alloc dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPages(cmdPages), .cmdPn(cmdPn), .ackAlloc(ackAlloc), .ackTx(ackTx),
    .rxArrive(rxArrive), .txDone(txDone), .busy(busy), .allocPn(allocPn),
    .allocFailed(allocFailed), .allocIrq(allocIrq), .txIrq(txIrq),
    .txDonePn(txDonePn), .rxPn(rxPn), .rxEmpty(rxEmpty), .freeUnits(freeUnits)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Command driven at a falling edge, sampled at the next rising edge.
  // Returns at the falling edge after that rising edge.
  task automatic issue(input int op, input int pages, input int pn);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdPages = 5'(pages); cmdPn = 2'(pn);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doAlloc(input int pages);
    issue(2, pages, 0);
    @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulseAckAlloc();
    @(negedge clk); ackAlloc = 1'b1;
    @(negedge clk); ackAlloc = 1'b0;
  endtask

  task automatic pulseAckTx();
    @(negedge clk); ackTx = 1'b1;
    @(negedge clk); ackTx = 1'b0;
  endtask

  task automatic pulseRx();
    @(negedge clk); rxArrive = 1'b1;
    @(negedge clk); rxArrive = 1'b0;
  endtask

  task automatic pulseTx();
    @(negedge clk); txDone = 1'b1;
    @(negedge clk); txDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int eff, field, cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 allocIrq", int'(allocIrq), 0);
    chk("R1 txIrq", int'(txIrq), 0);
    chk("R1 allocFailed", int'(allocFailed), 0);
    chk("R1 rxEmpty", int'(rxEmpty), 1);
    chk("R1 freeUnits", int'(freeUnits), NS);

    // Length sweep: page field computed from the length, pass iff field <= 7
    for (int len = 1; len <= 2100; len += 3) begin
      eff = (len < 60) ? 60 : len;
      field = ((eff & ~1) + 6) >> 8;
      doAlloc(field);
      if (field <= 7) begin
        chk("R2 sweep pass flag", int'(allocFailed), 0);
        chk("R2 sweep pn", int'(allocPn), 0);
        chk("R4 sweep irq set", int'(allocIrq), 1);
        chk("R12 sweep free", int'(freeUnits), NS - 1);
        pulseAckAlloc();
        chk("R4 sweep irq clear", int'(allocIrq), 0);
        issue(5, 0, 0);
        waitIdle();
        chk("R9 sweep freed", int'(freeUnits), NS);
      end else begin
        chk("R3 oversize flag", int'(allocFailed), 1);
        chk("R3 oversize no irq", int'(allocIrq), 0);
        chk("R3 oversize no slot", int'(freeUnits), NS);
      end
    end

    // Fill every slot, then one more
    for (int i = 0; i < NS; i++) begin
      doAlloc(1);
      chk("R2 fill pn", int'(allocPn), i);
      chk("R2 fill flag", int'(allocFailed), 0);
      chk("R12 fill free", int'(freeUnits), NS - 1 - i);
      pulseAckAlloc();
    end
    doAlloc(1);
    chk("R3 full flag", int'(allocFailed), 1);
    chk("R3 full no irq", int'(allocIrq), 0);
    chk("R3 full pn kept", int'(allocPn), NS - 1);

    // Free slot 2, then allocate while busy: must be dropped
    issue(5, 0, 2);
    issue(2, 1, 0);
    @(negedge clk);
    chk("R6 dropped alloc irq", int'(allocIrq), 0);
    chk("R6 dropped alloc slot", int'(freeUnits), 1);
    waitIdle();
    doAlloc(1);
    chk("R9 freed slot reused", int'(allocPn), 2);
    chk("R4 irq after reuse", int'(allocIrq), 1);
    pulseAckAlloc();

    // Busy length
    issue(5, 0, 3);
    cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
    chk("R5 busy cycles", cnt, 4);
    chk("R9 free count", int'(freeUnits), 1);

    // Reset
    issue(1, 0, 0);
    waitIdle();
    chk("R11 reset frees", int'(freeUnits), NS);
    chk("R11 reset rx empty", int'(rxEmpty), 1);

    // Receive path, plus grant and arrival in the same cycle
    pulseRx();
    chk("R7 rx head", int'(rxPn), 0);
    chk("R7 rx not empty", int'(rxEmpty), 0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd2; cmdPages = 5'd1;
    @(negedge clk);
    cmdValid = 1'b0; rxArrive = 1'b1;
    @(negedge clk);
    rxArrive = 1'b0;
    chk("R2 grant beats rx", int'(allocPn), 1);
    chk("R7 joint free", int'(freeUnits), 1);
    pulseAckAlloc();
    issue(4, 0, 0);
    chk("R8 release pops", int'(rxPn), 2);
    chk("R8 release frees", int'(freeUnits), 2);
    waitIdle();
    pulseRx();
    pulseRx();
    chk("R7 rx fill", int'(freeUnits), 0);
    pulseRx();
    chk("R7 rx dropped", int'(freeUnits), 0);
    chk("R7 order head", int'(rxPn), 2);
    issue(4, 0, 0); waitIdle();
    chk("R7 order second", int'(rxPn), 0);
    issue(4, 0, 0); waitIdle();
    chk("R7 order third", int'(rxPn), 3);
    issue(4, 0, 0); waitIdle();
    chk("R7 drained", int'(rxEmpty), 1);
    chk("R8 slots back", int'(freeUnits), 3);

    // Transmit path
    issue(3, 0, 1);
    issue(3, 0, 3);
    pulseTx();
    chk("R10 tx irq", int'(txIrq), 1);
    chk("R10 tx first", int'(txDonePn), 1);
    pulseAckTx();
    chk("R4 tx ack", int'(txIrq), 0);
    pulseTx();
    chk("R10 tx second", int'(txDonePn), 3);
    pulseAckTx();
    pulseTx();
    chk("R10 tx empty no irq", int'(txIrq), 0);
    issue(3, 0, 2);
    issue(1, 0, 0);
    waitIdle();
    pulseTx();
    chk("R11 reset empties tx", int'(txIrq), 0);
    chk("R12 after reset", int'(freeUnits), NS);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule